// File: doc/BRIEF.md
# Thermostat Alarm with Consecutive-Fault Filter

This block watches a stream of signed temperature samples and drives one alarm level. It compares each accepted sample against an upper trip point and a lower release point, and these two points form a hysteresis band. The alarm changes state only after a chosen number of back-to-back samples meet the current condition. That number can be 1, 2, 4 or 6. A single sample that misses the condition starts the count again.

In comparator mode the alarm follows the band directly. It turns on after enough hot samples and turns off after enough cool samples. In interrupt mode each crossing latches the alarm. A read-acknowledge pulse releases the latch, and the block then waits for a crossing in the opposite direction. The trip points and the configuration load through simple write strobes. Their reset values let the block act as a thermostat without any further writes.

Samples arrive on a valid/ready channel. The block never applies back-pressure: `samp_ready` is high in every cycle out of reset, and a sample is taken on any rising edge where `samp_valid` is high. Configuration and trip writes are plain strobes that take effect on the same edge.

Top module: `thst_alarm`

## Requirements
- R1: `samp_ready` reads 1 in every cycle out of reset, and each rising edge with `samp_valid` high accepts exactly one sample.
- R2: After reset, the upper trip point is +80.0 °C (9'h0A0) and the release point is +75.0 °C (9'h096). The filter count is 1, comparator mode and active-low output are selected, and the resolution is 9 bits. The alarm output therefore reads 1.
- R3: Samples are 12-bit two's complement with 1/16 °C per LSB. The resolution field r (00=9, 01=10, 10=11, 11=12 bits) zeroes the low 3-r bits before comparison. A sample is hot when the reduced sample is strictly greater than the upper point padded with three zero LSBs. It is cool when it is strictly less than the padded release point. All comparisons are signed.
- R4: The filter field (cfg bits [1:0]) encodes the count as 00=1, 01=2, 10=4, 11=6. An accepted sample that fails the awaited condition resets the run to zero. Cycles without `samp_valid` leave the run unchanged.
- R5: In comparator mode (cfg bit 2 = 0), the alarm turns on after the set number of consecutive hot samples. It turns off after the set number of consecutive cool samples.
- R6: Polarity is set by cfg bit 3. When it is 0, an active alarm drives `alarm_o` low. When it is 1, an active alarm drives `alarm_o` high.
- R7: In interrupt mode (cfg bit 2 = 1), the set number of consecutive hot samples latches the alarm. It stays on until an `rd_ack` pulse, whatever the samples, and samples taken while it is latched do not count.
- R8: After an acknowledge in interrupt mode, the block waits for the set number of consecutive cool samples. That run latches the alarm again, and the next acknowledge re-arms the block for hot samples. An `rd_ack` while nothing is latched has no effect.
- R9: A configuration write that changes the mode or filter field clears the run and any active or latched alarm, and the block returns to waiting for hot samples. A write that changes only the resolution or polarity keeps the alarm state.
- R10: `hi_we` and `lo_we` load a new 9-bit upper point and release point (0.5 °C per LSB). Later comparisons use the new values.
- R11: The alarm output changes on the clock edge that accepts the deciding sample, configuration write or acknowledge, and at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Sample channel valid |
| samp_ready | output | 1 | Sample channel ready, always high out of reset |
| samp_data | input | 12 | Signed sample, 1/16 °C per LSB |
| hi_we | input | 1 | Load upper trip point |
| hi_wdata | input | 9 | Upper trip point, signed, 0.5 °C per LSB |
| lo_we | input | 1 | Load release point |
| lo_wdata | input | 9 | Release point, signed, 0.5 °C per LSB |
| cfg_we | input | 1 | Load configuration |
| cfg_wdata | input | 6 | [1:0] filter count, [2] interrupt mode, [3] active-high, [5:4] resolution |
| rd_ack | input | 1 | Acknowledge pulse that releases a latched alarm |
| alarm_o | output | 1 | Alarm level after polarity |

## Verification
The assertions assume that every input is synchronous to `clk` and has a known value once reset is released. They also assume that `rd_ack` and the write strobes are single-cycle pulses, which the latch and clear properties rely on to decide what the next cycle should hold. The bench drives every input on the falling edge, holds each strobe for exactly one cycle and returns it to zero, and keeps all inputs at zero through reset. The stimulus therefore stays inside these assumptions.

// File: rtl/thst_pkg.sv
package thst_pkg;

  localparam int SAMPLE_W_D = 12;
  localparam int TRIP_W_D   = 9;
  localparam int RES_W_D    = 2;
  localparam int CNT_W_D    = 3;

  typedef enum logic [1:0] {
    ST_ARM_HI  = 2'd0,
    ST_ARM_LO  = 2'd1,
    ST_HOLD_HI = 2'd2,
    ST_HOLD_LO = 2'd3
  } arm_state_e;

  typedef struct packed {
    logic [1:0] res;
    logic       act_high;
    logic       intr;
    logic [1:0] flt;
  } cfg_t;

  localparam cfg_t CFG_RST = '{res: 2'b00, act_high: 1'b0, intr: 1'b0, flt: 2'b00};

  function automatic logic [CNT_W_D-1:0] run_target(input logic [1:0] sel);
    case (sel)
      2'b00:   run_target = CNT_W_D'(1);
      2'b01:   run_target = CNT_W_D'(2);
      2'b10:   run_target = CNT_W_D'(4);
      default: run_target = CNT_W_D'(6);
    endcase
  endfunction

endpackage

// File: rtl/thst_quantize.sv
module thst_quantize #(
  parameter int SAMPLE_W = thst_pkg::SAMPLE_W_D,
  parameter int TRIP_W   = thst_pkg::TRIP_W_D,
  parameter int RES_W    = thst_pkg::RES_W_D
) (
  input  logic [SAMPLE_W-1:0] raw,
  input  logic [RES_W-1:0]    res,
  output logic [SAMPLE_W-1:0] q
);
  localparam int EXTRA = SAMPLE_W - TRIP_W;

  // Bits at and above EXTRA always carry data; below it, resolution unmasks
  // one more fractional bit per step.
  for (genvar b = 0; b < SAMPLE_W; b++) begin : g_bit
    if (b >= EXTRA) begin : g_keep
      assign q[b] = raw[b];
    end else begin : g_mask
      assign q[b] = raw[b] & (res > RES_W'(EXTRA - 1 - b));
    end
  end
endmodule

// File: rtl/thst_fault_cnt.sv
module thst_fault_cnt #(
  parameter int CNT_W = thst_pkg::CNT_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_en,
  input  logic             fault,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);
  assign hit     = step_en & fault & (cnt_inc == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (step_en) begin
      if (fault && !hit) cnt <= cnt_inc;
      else               cnt <= '0;
    end
  end
endmodule

// File: rtl/thst_alarm_fsm.sv
module thst_alarm_fsm
  import thst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic intr,
  input  logic hit,
  input  logic ack,
  output logic arming,
  output logic watch_low,
  output logic active
);
  arm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ARM_HI:  if (hit) st_d = intr ? ST_HOLD_HI : ST_ARM_LO;
      ST_ARM_LO:  if (hit) st_d = intr ? ST_HOLD_LO : ST_ARM_HI;
      ST_HOLD_HI: if (ack) st_d = ST_ARM_LO;
      ST_HOLD_LO: if (ack) st_d = ST_ARM_HI;
      default:    st_d = ST_ARM_HI;
    endcase
    if (clr) st_d = ST_ARM_HI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ARM_HI;
    else        st_q <= st_d;
  end

  assign arming    = (st_q == ST_ARM_HI) || (st_q == ST_ARM_LO);
  assign watch_low = (st_q == ST_ARM_LO);
  assign active    = intr ? ((st_q == ST_HOLD_HI) || (st_q == ST_HOLD_LO))
                          : (st_q == ST_ARM_LO);
endmodule

// File: rtl/thst_alarm.sv
module thst_alarm
  import thst_pkg::*;
#(
  parameter int             SAMPLE_W = SAMPLE_W_D,
  parameter int             TRIP_W   = TRIP_W_D,
  parameter int             RES_W    = RES_W_D,
  parameter int             CNT_W    = CNT_W_D,
  parameter logic [TRIP_W-1:0] HI_RST = TRIP_W'(160),
  parameter logic [TRIP_W-1:0] LO_RST = TRIP_W'(150)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_valid,
  output logic                samp_ready,
  input  logic [SAMPLE_W-1:0] samp_data,
  input  logic                hi_we,
  input  logic [TRIP_W-1:0]   hi_wdata,
  input  logic                lo_we,
  input  logic [TRIP_W-1:0]   lo_wdata,
  input  logic                cfg_we,
  input  logic [5:0]          cfg_wdata,
  input  logic                rd_ack,
  output logic                alarm_o
);
  localparam int EXTRA = SAMPLE_W - TRIP_W;

  logic [TRIP_W-1:0]   hi_q, lo_q;
  cfg_t                cfg_q, cfg_in;
  logic                cfg_chg;
  logic                intr_mode;
  logic [SAMPLE_W-1:0] samp_q;
  logic [SAMPLE_W-1:0] hi_ext, lo_ext;
  logic                is_hot, is_cool, fault;
  logic                arming, watch_low, alarm_act;
  logic                step_en, hit;
  logic [CNT_W-1:0]    fault_cnt, cnt_target;

  assign cfg_in = cfg_t'(cfg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= HI_RST;
      lo_q  <= LO_RST;
      cfg_q <= CFG_RST;
    end else begin
      if (hi_we)  hi_q  <= hi_wdata;
      if (lo_we)  lo_q  <= lo_wdata;
      if (cfg_we) cfg_q <= cfg_in;
    end
  end

  assign cfg_chg   = cfg_we && ((cfg_in.intr != cfg_q.intr) || (cfg_in.flt != cfg_q.flt));
  assign intr_mode = cfg_q.intr;
  assign samp_ready = rst_n;

  thst_quantize #(.SAMPLE_W(SAMPLE_W), .TRIP_W(TRIP_W), .RES_W(RES_W)) u_quant (
    .raw (samp_data),
    .res (cfg_q.res),
    .q   (samp_q)
  );

  assign hi_ext  = {hi_q, {EXTRA{1'b0}}};
  assign lo_ext  = {lo_q, {EXTRA{1'b0}}};
  assign is_hot  = $signed(samp_q) > $signed(hi_ext);
  assign is_cool = $signed(samp_q) < $signed(lo_ext);
  assign fault   = watch_low ? is_cool : is_hot;

  assign cnt_target = CNT_W'(run_target(cfg_q.flt));
  assign step_en    = samp_valid & samp_ready & arming & ~cfg_chg;

  thst_fault_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_chg),
    .step_en (step_en),
    .fault   (fault),
    .target  (cnt_target),
    .cnt     (fault_cnt),
    .hit     (hit)
  );

  thst_alarm_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cfg_chg),
    .intr      (intr_mode),
    .hit       (hit),
    .ack       (rd_ack),
    .arming    (arming),
    .watch_low (watch_low),
    .active    (alarm_act)
  );

  assign alarm_o = cfg_q.act_high ? alarm_act : ~alarm_act;
endmodule

// File: rtl/thst_alarm_chk.sv
module thst_alarm_chk #(
  parameter int CNT_W = thst_pkg::CNT_W_D
) (
  input logic             clk,
  input logic             rst_n,
  input logic             samp_valid,
  input logic             rd_ack,
  input logic             cfg_we,
  input logic             cfg_chg,
  input logic             intr_mode,
  input logic             alarm_act,
  input logic [CNT_W-1:0] fault_cnt,
  input logic [CNT_W-1:0] cnt_target
);
  // R4: the run never reaches the target while it is being counted
  a_r4_run_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt < cnt_target);

  // R7: a latched alarm survives any cycle without an acknowledge or config write
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_mode && alarm_act && !rd_ack && !cfg_we) |=> alarm_act);

  // R8: an acknowledge releases a latched alarm
  a_r8_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_mode && alarm_act && rd_ack && !cfg_we) |=> !alarm_act);

  // R9: a mode or filter change clears run and alarm
  a_r9_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (fault_cnt == '0) && !alarm_act);

  // R11: without a sample, acknowledge or write, the alarm holds
  a_r11_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_valid && !rd_ack && !cfg_we) |=> $stable(alarm_act));
endmodule

bind thst_alarm thst_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_valid (samp_valid),
  .rd_ack     (rd_ack),
  .cfg_we     (cfg_we),
  .cfg_chg    (cfg_chg),
  .intr_mode  (intr_mode),
  .alarm_act  (alarm_act),
  .fault_cnt  (fault_cnt),
  .cnt_target (cnt_target)
);

// File: tb/sim_thst_alarm.sv
`timescale 1ns/1ps
module sim_thst_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [11:0] samp_data = '0;
  logic        hi_we = 1'b0;
  logic [8:0]  hi_wdata = '0;
  logic        lo_we = 1'b0;
  logic [8:0]  lo_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic        rd_ack = 1'b0;
  logic        alarm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  thst_alarm u0 (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_data(samp_data), .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we),
    .lo_wdata(lo_wdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_ack(rd_ack),
    .alarm_o(alarm_o)
  );

  // {expected alarm_o after the sample, sample}; default config, active low
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 12'h100},   // 16 C, quiet
    {1'b1, 12'h500},   // exactly 80 C, not above
    {1'b0, 12'h508},   // 80.5 C, fires
    {1'b0, 12'h4B0},   // exactly 75 C, not below
    {1'b1, 12'h4AF},   // 74.94 C reduced to 74.5 C, releases
    {1'b1, 12'h507},   // 80.44 C reduced to 80.0 C, quiet
    {1'b1, 12'hE00},   // negative, quiet
    {1'b0, 12'h7F0}    // 127 C, fires
  };

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm_o=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [11:0] d);
    @(negedge clk);
    samp_valid = 1'b1; samp_data = d;
    @(negedge clk);
    samp_valid = 1'b0; samp_data = '0;
  endtask

  task automatic idle(input logic [11:0] d);
    @(negedge clk);
    samp_valid = 1'b0; samp_data = d;
    @(negedge clk);
    samp_data = '0;
  endtask

  task automatic cfg(input logic [5:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trips(input logic [8:0] hi, input logic [8:0] lo);
    @(negedge clk);
    hi_we = 1'b1; hi_wdata = hi; lo_we = 1'b1; lo_wdata = lo;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset level", alarm_o, 1'b1);
    check("R1 ready", samp_ready, 1'b1);

    // R2 R3 R5: default trip points in comparator mode
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][11:0]);
      check($sformatf("R3 R5 vector %0d", i), alarm_o, VEC[i][12]);
    end
    send(12'h100);
    check("R5 release", alarm_o, 1'b1);

    // R4: filter of 6, broken run restarts
    cfg(6'b000011);
    for (int i = 0; i < 5; i++) send(12'h600);
    check("R4 five hot of six", alarm_o, 1'b1);
    send(12'h100);
    for (int i = 0; i < 5; i++) send(12'h600);
    check("R4 restarted run", alarm_o, 1'b1);
    send(12'h600);
    check("R4 sixth hot fires", alarm_o, 1'b0);
    for (int i = 0; i < 5; i++) send(12'h100);
    check("R4 five cool of six", alarm_o, 1'b0);
    send(12'h100);
    check("R4 sixth cool releases", alarm_o, 1'b1);

    // R4: idle cycles do not break the run (filter of 2)
    cfg(6'b000001);
    send(12'h600);
    check("R4 first of two", alarm_o, 1'b1);
    idle(12'h100);
    send(12'h600);
    check("R4 idle cycle ignored", alarm_o, 1'b0);

    // R9: unchanged write keeps state; changed filter clears
    cfg(6'b000001);
    check("R9 same write keeps", alarm_o, 1'b0);
    cfg(6'b000000);
    check("R9 filter change clears", alarm_o, 1'b1);

    // R3: resolution
    cfg(6'b110000);
    send(12'h501);
    check("R3 12-bit fires", alarm_o, 1'b0);
    send(12'h4AF);
    check("R3 12-bit releases", alarm_o, 1'b1);
    cfg(6'b010000);
    send(12'h503);
    check("R3 10-bit drops bits", alarm_o, 1'b1);

    // R6: polarity
    cfg(6'b011000);
    check("R6 active high idle", alarm_o, 1'b0);
    send(12'h600);
    check("R6 active high alarm", alarm_o, 1'b1);
    send(12'h100);
    cfg(6'b000000);
    check("R6 back to active low", alarm_o, 1'b1);

    // R10: new trip points 32 C / 30 C
    trips(9'h040, 9'h03C);
    send(12'h210);
    check("R10 new upper", alarm_o, 1'b0);
    send(12'h1F0);
    check("R10 inside band", alarm_o, 1'b0);
    send(12'h1D0);
    check("R10 new release", alarm_o, 1'b1);

    // R7 R8: interrupt mode
    cfg(6'b000100);
    send(12'h300);
    check("R7 hot latches", alarm_o, 1'b0);
    send(12'h100);
    check("R7 held while latched", alarm_o, 1'b0);
    ack();
    check("R8 ack releases", alarm_o, 1'b1);
    send(12'h300);
    check("R8 armed for cool", alarm_o, 1'b1);
    send(12'h100);
    check("R8 cool latches", alarm_o, 1'b0);
    ack();
    check("R8 second ack", alarm_o, 1'b1);
    ack();
    check("R8 stray ack ignored", alarm_o, 1'b1);
    send(12'h300);
    check("R8 rearmed for hot", alarm_o, 1'b0);
    cfg(6'b000000);
    check("R9 mode change clears latch", alarm_o, 1'b1);

    // R3: signed trip points -5 C / -8 C
    trips(9'h1F6, 9'h1F0);
    send(12'hFC0);
    check("R3 negative above", alarm_o, 1'b0);
    send(12'hF70);
    check("R3 negative below", alarm_o, 1'b1);

    // R11: no change without an event
    idle(12'h7F0);
    check("R11 no sample no change", alarm_o, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule